// File: doc/BRIEF.md
# Interrupt-Triggered Single-Move Transfer Engine

This block answers a granted top-priority interrupt by copying one item of data rather than running a service routine. It holds eight transfer channels, and each one can be programmed on its own. Every channel keeps a 16-bit source pointer, a 16-bit destination pointer, a transfer count and a control field. The control field selects byte or word width and whether each pointer advances. Both pointers address the lowest 64 KB segment.

When the interrupt arbiter grants a channel, the engine reads once from the source and writes that value once to the destination, over a simple request/acknowledge memory bus. It then advances the channel's pointers, decrements its count and pulses a completion strobe. The CPU is held off only while this happens, and no program status is saved. A channel whose count has run out moves nothing; it hands the request back as an ordinary interrupt. Grants that arrive while a move is running are remembered and served afterwards.

The sequencer has five named states. IDLE waits for a request. READ runs the source read. WRITE runs the destination write. UPDATE advances the channel registers and signals completion. FORWARD hands a spent channel's request back.

The transitions are:
- IDLE goes to READ when the picked channel's count is non-zero.
- IDLE goes to FORWARD when that count is zero.
- READ goes to WRITE on the read acknowledge.
- WRITE goes to UPDATE on the write acknowledge.
- UPDATE returns to IDLE unconditionally.
- FORWARD returns to IDLE unconditionally.

Top module: `evx_engine`

## Requirements
- R1: Each of the eight channels is programmed through the configuration port. `cfg_sel` chooses the field: 0 is the source pointer, 1 is the destination pointer, 2 is the count and 3 is the control field. In the control field, bit 0 selects word mode, bit 1 enables destination increment and bit 2 enables source increment. `cfg_rdata` returns the selected field of `cfg_chan` combinationally, zero-extended to 16 bits.
- R2: A granted channel with a non-zero count first issues one read (`mem_we`=0) at the source pointer and then one write (`mem_we`=1) at the destination pointer that carries the data just read. In byte mode `mem_byte` is 1, only `mem_rdata[7:0]` is used, and `mem_wdata[15:8]` is zero.
- R3: In word mode `mem_byte` is 0, address bit 0 is driven as 0 for both phases, and all 16 data bits are moved.
- R4: A bus phase keeps `mem_req`, `mem_addr` and `mem_we` unchanged until the cycle in which `mem_ack` is high, and that phase ends in that cycle.
- R5: After the write is acknowledged, the count drops by one. A pointer whose increment bit is set advances by 1 in byte mode or by 2 in word mode, wrapping at 16 bits. A pointer whose bit is clear keeps its value. `xfer_done` pulses for one cycle with `done_chan` set to the channel, and it never coincides with `irq_fwd`.
- R6: A granted channel with a zero count makes no bus access and leaves its registers unchanged. Instead it pulses `irq_fwd` for one cycle with `fwd_chan` set to that channel, and `cpu_stall` stays low in that cycle.
- R7: `cpu_stall` goes high in the cycle after the grant of a move and stays high up to and including the `xfer_done` cycle. It is low otherwise, and it is always high while `mem_req` is high.
- R8: A grant that arrives while the engine is busy is held and served after the current one. Among held channels, the highest channel number is served first. Repeated grants of a channel that is already held count as one.
- R9: Configuration writes presented while `cpu_stall` is high are ignored.
- R10: Reset clears every channel field to zero and leaves the engine idle, with `mem_req`, `cpu_stall`, `xfer_done` and `irq_fwd` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 3 | Channel addressed for configuration write and read |
| cfg_sel | input | 2 | Field select (0 src, 1 dst, 2 count, 3 control) |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Selected field of the addressed channel |
| trig_valid | input | 1 | Arbiter grant strobe |
| trig_chan | input | 3 | Granted channel |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_byte | output | 1 | Byte-wide access when 1 |
| mem_addr | output | 16 | Bus byte address |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data |
| mem_ack | input | 1 | Bus acknowledge, ends the current phase |
| cpu_stall | output | 1 | Holds the CPU during a move |
| xfer_done | output | 1 | One-cycle completion pulse |
| done_chan | output | 3 | Channel that completed |
| irq_fwd | output | 1 | One-cycle pulse handing a spent channel to normal interrupt service |
| fwd_chan | output | 3 | Channel being handed back |

## Verification
Faults inside the engine surface on the bus or on the strobes at the next grant of the affected channel. A corrupted pointer appears as a wrong `mem_addr` in the very next read or write phase. A wrong count makes `irq_fwd` fire early, or `xfer_done` fire where a hand-back was due, one cycle after that channel's next grant. A lost or misordered held grant shows up as a `done_chan` sequence that differs from the expected order within the one move that follows the current one. The bench therefore predicts every bus phase and every strobe, compares each one as it occurs, and reads all channel fields back after each scenario.

// File: rtl/evx_pkg.sv
package evx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_WRITE   = 3'd2,
        ST_UPDATE  = 3'd3,
        ST_FORWARD = 3'd4
    } evx_state_e;

    localparam logic [1:0] FLD_SRC = 2'd0;
    localparam logic [1:0] FLD_DST = 2'd1;
    localparam logic [1:0] FLD_CNT = 2'd2;
    localparam logic [1:0] FLD_CTL = 2'd3;

    localparam int PTR_W = 16;
    localparam int DAT_W = 16;

    // Control field, bit 2 down to bit 0: source step, destination step, word width
    typedef struct packed {
        logic src_inc;
        logic dst_inc;
        logic word;
    } evx_ctl_t;

endpackage

// File: rtl/evx_chan_regs.sv
module evx_chan_regs
    import evx_pkg::*;
#(
    parameter int NCHAN = 8,
    parameter int CNT_W = 8,
    parameter int CH_W  = $clog2(NCHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [1:0]        wr_sel,
    input  logic [DAT_W-1:0]  wr_data,
    output logic [DAT_W-1:0]  rd_data,
    input  logic [CH_W-1:0]   act_chan,
    input  logic              upd_en,
    output logic [PTR_W-1:0]  act_src,
    output logic [PTR_W-1:0]  act_dst,
    output logic              act_word,
    output logic [NCHAN-1:0]  cnt_zero
);

    logic [PTR_W-1:0] src_q [NCHAN];
    logic [PTR_W-1:0] dst_q [NCHAN];
    logic [CNT_W-1:0] cnt_q [NCHAN];
    evx_ctl_t         ctl_q [NCHAN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCHAN; i++) begin
                src_q[i] <= '0;
                dst_q[i] <= '0;
                cnt_q[i] <= '0;
                ctl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NCHAN; i++) begin
                if (upd_en && act_chan == CH_W'(i)) begin
                    if (ctl_q[i].src_inc)
                        src_q[i] <= src_q[i] + (ctl_q[i].word ? 16'd2 : 16'd1);
                    if (ctl_q[i].dst_inc)
                        dst_q[i] <= dst_q[i] + (ctl_q[i].word ? 16'd2 : 16'd1);
                    cnt_q[i] <= cnt_q[i] - 1'b1;
                end else if (wr_en && wr_chan == CH_W'(i)) begin
                    unique case (wr_sel)
                        FLD_SRC: src_q[i] <= wr_data;
                        FLD_DST: dst_q[i] <= wr_data;
                        FLD_CNT: cnt_q[i] <= wr_data[CNT_W-1:0];
                        FLD_CTL: ctl_q[i] <= evx_ctl_t'(wr_data[2:0]);
                        default: ;
                    endcase
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NCHAN; g++) begin : g_zero
            assign cnt_zero[g] = (cnt_q[g] == '0);
        end
    endgenerate

    always_comb begin
        unique case (wr_sel)
            FLD_SRC: rd_data = src_q[wr_chan];
            FLD_DST: rd_data = dst_q[wr_chan];
            FLD_CNT: rd_data = DAT_W'(cnt_q[wr_chan]);
            FLD_CTL: rd_data = DAT_W'(ctl_q[wr_chan]);
            default: rd_data = '0;
        endcase
    end

    assign act_src  = src_q[act_chan];
    assign act_dst  = dst_q[act_chan];
    assign act_word = ctl_q[act_chan].word;

endmodule

// File: rtl/evx_req_pick.sv
module evx_req_pick #(
    parameter int NCHAN = 8,
    parameter int CH_W  = $clog2(NCHAN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_valid,
    input  logic [CH_W-1:0] trig_chan,
    input  logic            take,
    output logic            any_req,
    output logic [CH_W-1:0] pick_chan
);

    logic [NCHAN-1:0] held_q;
    logic [NCHAN-1:0] req_vec;
    logic [NCHAN-1:0] held_d;

    always_comb begin
        req_vec = held_q;
        if (trig_valid)
            req_vec[trig_chan] = 1'b1;
        pick_chan = '0;
        for (int i = 0; i < NCHAN; i++) begin
            if (req_vec[i])
                pick_chan = CH_W'(i);
        end
        any_req = |req_vec;
        held_d  = req_vec;
        if (take)
            held_d[pick_chan] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_q <= '0;
        else
            held_q <= held_d;
    end

endmodule

// File: rtl/evx_seq.sv
module evx_seq
    import evx_pkg::*;
#(
    parameter int NCHAN = 8,
    parameter int CH_W  = $clog2(NCHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [CH_W-1:0]   pick_chan,
    input  logic [NCHAN-1:0]  cnt_zero,
    input  logic [PTR_W-1:0]  act_src,
    input  logic [PTR_W-1:0]  act_dst,
    input  logic              act_word,
    input  logic [DAT_W-1:0]  mem_rdata,
    input  logic              mem_ack,
    output logic              take,
    output logic [CH_W-1:0]   act_chan,
    output logic              upd_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DAT_W-1:0]  mem_wdata,
    output logic              cpu_stall,
    output logic              xfer_done,
    output logic [CH_W-1:0]   done_chan,
    output logic              irq_fwd,
    output logic [CH_W-1:0]   fwd_chan
);

    evx_state_e       state_q, state_d;
    logic [DAT_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_req) state_d = cnt_zero[pick_chan] ? ST_FORWARD : ST_READ;
            ST_READ:    if (mem_ack) state_d = ST_WRITE;
            ST_WRITE:   if (mem_ack) state_d = ST_UPDATE;
            ST_UPDATE:  state_d = ST_IDLE;
            ST_FORWARD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_chan <= '0;
            data_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && any_req)
                act_chan <= pick_chan;
            if (state_q == ST_READ && mem_ack)
                data_q <= act_word ? mem_rdata : {8'h00, mem_rdata[7:0]};
        end
    end

    always_comb begin
        take      = 1'b0;
        upd_en    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        cpu_stall = 1'b0;
        xfer_done = 1'b0;
        done_chan = '0;
        irq_fwd   = 1'b0;
        fwd_chan  = '0;
        unique case (state_q)
            ST_IDLE: take = any_req;
            ST_READ: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_byte  = !act_word;
                mem_addr  = act_word ? {act_src[PTR_W-1:1], 1'b0} : act_src;
            end
            ST_WRITE: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = !act_word;
                mem_addr  = act_word ? {act_dst[PTR_W-1:1], 1'b0} : act_dst;
                mem_wdata = data_q;
            end
            ST_UPDATE: begin
                cpu_stall = 1'b1;
                upd_en    = 1'b1;
                xfer_done = 1'b1;
                done_chan = act_chan;
            end
            ST_FORWARD: begin
                irq_fwd  = 1'b1;
                fwd_chan = act_chan;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/evx_engine.sv
module evx_engine
    import evx_pkg::*;
#(
    parameter int NCHAN = 8,
    parameter int CNT_W = 8,
    localparam int CH_W = $clog2(NCHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [1:0]        cfg_sel,
    input  logic [DAT_W-1:0]  cfg_wdata,
    output logic [DAT_W-1:0]  cfg_rdata,
    input  logic              trig_valid,
    input  logic [CH_W-1:0]   trig_chan,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DAT_W-1:0]  mem_wdata,
    input  logic [DAT_W-1:0]  mem_rdata,
    input  logic              mem_ack,
    output logic              cpu_stall,
    output logic              xfer_done,
    output logic [CH_W-1:0]   done_chan,
    output logic              irq_fwd,
    output logic [CH_W-1:0]   fwd_chan
);

    logic             take;
    logic             any_req;
    logic [CH_W-1:0]  pick_chan;
    logic [CH_W-1:0]  act_chan;
    logic             upd_en;
    logic [PTR_W-1:0] act_src;
    logic [PTR_W-1:0] act_dst;
    logic             act_word;
    logic [NCHAN-1:0] cnt_zero;
    logic             wr_ok;

    // The CPU cannot program channels while it is held
    assign wr_ok = cfg_we && !cpu_stall;

    evx_chan_regs #(.NCHAN(NCHAN), .CNT_W(CNT_W), .CH_W(CH_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_chan  (cfg_chan),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .rd_data  (cfg_rdata),
        .act_chan (act_chan),
        .upd_en   (upd_en),
        .act_src  (act_src),
        .act_dst  (act_dst),
        .act_word (act_word),
        .cnt_zero (cnt_zero)
    );

    evx_req_pick #(.NCHAN(NCHAN), .CH_W(CH_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_valid (trig_valid),
        .trig_chan  (trig_chan),
        .take       (take),
        .any_req    (any_req),
        .pick_chan  (pick_chan)
    );

    evx_seq #(.NCHAN(NCHAN), .CH_W(CH_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req),
        .pick_chan (pick_chan),
        .cnt_zero  (cnt_zero),
        .act_src   (act_src),
        .act_dst   (act_dst),
        .act_word  (act_word),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .take      (take),
        .act_chan  (act_chan),
        .upd_en    (upd_en),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_byte  (mem_byte),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cpu_stall (cpu_stall),
        .xfer_done (xfer_done),
        .done_chan (done_chan),
        .irq_fwd   (irq_fwd),
        .fwd_chan  (fwd_chan)
    );

endmodule

// File: rtl/evx_engine_chk.sv
module evx_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_byte,
    input logic [15:0] mem_addr,
    input logic        mem_ack,
    input logic        cpu_stall,
    input logic        xfer_done,
    input logic        irq_fwd
);

    p_stall_on_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);

    p_fwd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fwd |-> (!cpu_stall && !mem_req));

    p_hold_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_byte) |-> !mem_addr[0]);

    p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_req && mem_we)) |-> $past(mem_req && mem_ack && !mem_we));

    p_done_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(mem_req && mem_we && mem_ack));

    p_done_not_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !irq_fwd);

endmodule

bind evx_engine evx_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_byte  (mem_byte),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .cpu_stall (cpu_stall),
    .xfer_done (xfer_done),
    .irq_fwd   (irq_fwd)
);

// File: tb/evx_engine_bench.sv
`timescale 1ns/1ps
module evx_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_chan = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        trig_valid = 1'b0;
    logic [2:0]  trig_chan = '0;
    logic        mem_req, mem_we, mem_byte;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        cpu_stall, xfer_done, irq_fwd;
    logic [2:0]  done_chan, fwd_chan;

    always #10 clk = ~clk;

    evx_engine u_evx_engine (.*);

    int checks = 0;
    int errors = 0;

    typedef struct {int kind; int addr; int byte_m; int data; int chan;} ev_t;
    ev_t exp_q[$];

    logic [7:0] bus_mem [int];
    logic [7:0] ref_mem [int];
    int m_src[8], m_dst[8], m_cnt[8], m_ctl[8];
    bit m_busy = 0;
    bit [7:0] m_pend = '0;
    int lat = 0;
    int wcnt = 0;

    function automatic logic [7:0] seed_byte(int a);
        return 8'((a * 7) + ((a >> 8) * 13) + 5);
    endfunction
    function automatic logic [7:0] bus_rd(int a);
        return bus_mem.exists(a) ? bus_mem[a] : seed_byte(a);
    endfunction
    function automatic logic [7:0] ref_rd(int a);
        return ref_mem.exists(a) ? ref_mem[a] : seed_byte(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural prediction of one grant of channel c
    task automatic expand(input int c);
        int w, ra, wa, d, st;
        ev_t e;
        if (m_cnt[c] == 0) begin
            e = '{3, 0, 0, 0, c}; exp_q.push_back(e);
            return;
        end
        w  = m_ctl[c] & 1;
        ra = w ? (m_src[c] & 'hFFFE) : m_src[c];
        wa = w ? (m_dst[c] & 'hFFFE) : m_dst[c];
        d  = w ? {ref_rd(ra + 1), ref_rd(ra)} : int'(ref_rd(ra));
        e = '{0, ra, !w, d, c}; exp_q.push_back(e);
        ref_mem[wa] = d[7:0];
        if (w) ref_mem[wa + 1] = d[15:8];
        e = '{1, wa, !w, d, c}; exp_q.push_back(e);
        e = '{2, 0, 0, 0, c}; exp_q.push_back(e);
        st = w ? 2 : 1;
        if (m_ctl[c] & 4) m_src[c] = (m_src[c] + st) & 'hFFFF;
        if (m_ctl[c] & 2) m_dst[c] = (m_dst[c] + st) & 'hFFFF;
        m_cnt[c] = m_cnt[c] - 1;
    endtask

    task automatic serve_next();
        bit found;
        found = 0;
        m_busy = 0;
        for (int i = 7; i >= 0; i--) begin
            if (!found && m_pend[i]) begin
                found = 1;
                m_pend[i] = 1'b0;
                expand(i);
                m_busy = 1;
            end
        end
    endtask

    // Memory responder and per-clock comparison
    initial begin
        ev_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mem_ack) begin
                    mem_ack = 1'b0;
                    wcnt = 0;
                end else if (mem_req) begin
                    chk(cpu_stall == 1'b1, "R7", "stall during bus phase", cpu_stall, 1);
                    if (wcnt >= lat) begin
                        if (exp_q.size() == 0 || exp_q[0].kind > 1) begin
                            chk(0, "R2", "unexpected bus phase at", mem_addr, 0);
                        end else begin
                            e = exp_q.pop_front();
                            chk(mem_we == (e.kind == 1), e.byte_m ? "R2" : "R3", "direction", mem_we, e.kind);
                            chk(mem_addr == 16'(e.addr), e.byte_m ? "R2" : "R3", "address", mem_addr, e.addr);
                            chk(mem_byte == e.byte_m[0], e.byte_m ? "R2" : "R3", "width", mem_byte, e.byte_m);
                            if (e.kind == 1) begin
                                chk(mem_wdata == 16'(e.data), e.byte_m ? "R2" : "R3", "write data", mem_wdata, e.data);
                                bus_mem[int'(mem_addr)] = mem_wdata[7:0];
                                if (!mem_byte) bus_mem[int'(mem_addr) + 1] = mem_wdata[15:8];
                            end else begin
                                mem_rdata = mem_byte ? {8'hA5, bus_rd(int'(mem_addr))}
                                                     : {bus_rd(int'(mem_addr) + 1), bus_rd(int'(mem_addr))};
                            end
                        end
                        mem_ack = 1'b1;
                    end else begin
                        wcnt++;
                    end
                end
                if (xfer_done) begin
                    if (exp_q.size() == 0) chk(0, "R5", "unexpected done", done_chan, 0);
                    else begin
                        e = exp_q.pop_front();
                        chk(e.kind == 2 && done_chan == 3'(e.chan), "R5,R8", "done channel", done_chan, e.chan);
                    end
                    serve_next();
                end
                if (irq_fwd) begin
                    chk(cpu_stall == 1'b0, "R6", "stall during hand-back", cpu_stall, 0);
                    if (exp_q.size() == 0) chk(0, "R6", "unexpected hand-back", fwd_chan, 0);
                    else begin
                        e = exp_q.pop_front();
                        chk(e.kind == 3 && fwd_chan == 3'(e.chan), "R6", "hand-back channel", fwd_chan, e.chan);
                    end
                    serve_next();
                end
            end
        end
    end

    task automatic fire(input int c);
        bit idle_now, zero_now;
        @(negedge clk);
        idle_now = !m_busy;
        zero_now = (m_cnt[c] == 0);
        trig_valid = 1'b1;
        trig_chan = 3'(c);
        if (!m_busy) begin expand(c); m_busy = 1; end
        else m_pend[c] = 1'b1;
        @(negedge clk);
        trig_valid = 1'b0;
        if (idle_now) begin
            if (zero_now) chk(irq_fwd == 1'b1 && cpu_stall == 1'b0, "R6", "hand-back one cycle after grant", irq_fwd, 1);
            else chk(cpu_stall == 1'b1, "R7", "stall one cycle after grant", cpu_stall, 1);
        end
    endtask

    task automatic cfg_raw(input int c, input int sel, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 3'(c); cfg_sel = 2'(sel); cfg_wdata = 16'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg(input int c, input int src, input int dst, input int cnt, input int ctl);
        cfg_raw(c, 0, src); m_src[c] = src;
        cfg_raw(c, 1, dst); m_dst[c] = dst;
        cfg_raw(c, 2, cnt); m_cnt[c] = cnt;
        cfg_raw(c, 3, ctl); m_ctl[c] = ctl;
    endtask

    task automatic check_regs(input int c, input string req);
        int exp_v;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            cfg_chan = 3'(c); cfg_sel = 2'(s);
            #1;
            exp_v = (s == 0) ? m_src[c] : (s == 1) ? m_dst[c] : (s == 2) ? m_cnt[c] : m_ctl[c];
            chk(cfg_rdata == 16'(exp_v), req, "field readback", cfg_rdata, exp_v);
        end
    endtask

    task automatic wait_idle();
        while (m_busy || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(cpu_stall == 1'b0, "R7", "stall released after done", cpu_stall, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(cpu_stall == 0 && mem_req == 0 && xfer_done == 0 && irq_fwd == 0, "R10", "idle outputs", cpu_stall, 0);
        check_regs(0, "R10");
        check_regs(5, "R10");

        // R6: zero count hands the request back
        fire(0);
        wait_idle();
        check_regs(0, "R6");

        // R1, R2, R5: byte moves with both pointers stepping, then a hand-back
        cfg(1, 'h1000, 'h2000, 3, 6);
        check_regs(1, "R1");
        lat = 0;
        for (int k = 0; k < 3; k++) begin fire(1); wait_idle(); end
        check_regs(1, "R5");
        fire(1); wait_idle();
        check_regs(1, "R6");

        // R3, R4: word moves from odd pointers, no stepping, slow bus
        cfg(2, 'h3001, 'h4005, 2, 1);
        lat = 2;
        fire(2); wait_idle();
        fire(2); wait_idle();
        check_regs(2, "R3");

        // R5: word mode, source step only, wrap near top of segment
        cfg(3, 'hFFFE, 'h6000, 2, 5);
        lat = 1;
        fire(3); wait_idle();
        fire(3); wait_idle();
        check_regs(3, "R5");

        // R8: held grants served highest first, repeats merged
        cfg(4, 'h0100, 'h0200, 1, 6);
        cfg(5, 'h0110, 'h0210, 2, 6);
        cfg(6, 'h0120, 'h0220, 1, 6);
        lat = 3;
        fire(4);
        fire(5);
        fire(5);
        fire(6);
        wait_idle();
        check_regs(5, "R8");
        check_regs(6, "R8");

        // R9: configuration writes during a stall are dropped
        cfg(7, 'h0300, 'h0400, 1, 0);
        lat = 3;
        fire(7);
        chk(cpu_stall == 1'b1, "R9", "stall before write", cpu_stall, 1);
        cfg_raw(7, 2, 9);
        cfg_raw(7, 0, 'h1234);
        wait_idle();
        check_regs(7, "R9");

        // R2, R3: destination memory contents
        for (int a = 'h2000; a < 'h2003; a++)
            chk(bus_rd(a) == ref_rd(a), "R2", "byte destination", bus_rd(a), ref_rd(a));
        for (int a = 'h4004; a < 'h4006; a++)
            chk(bus_rd(a) == ref_rd(a), "R3", "word destination", bus_rd(a), ref_rd(a));
        for (int a = 'h6000; a < 'h6002; a++)
            chk(bus_rd(a) == ref_rd(a), "R3", "word destination", bus_rd(a), ref_rd(a));
        chk(exp_q.size() == 0, "R8", "outstanding expectations", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule